// File: doc/BRIEF.md
# Width-Converting Byte FIFO with Selectable Read Timing

This block is a single-clock queue whose write side and read side are each either 9 or 18 bits wide, chosen independently while the master reset is held. Inside, everything is kept as a sequence of 9-bit bytes. An 18-bit write splits into two bytes, and an 18-bit read joins two bytes into one word. A byte-order input decides whether the earlier byte of a pair sits in the upper or the lower half of an 18-bit word.

There are two read disciplines. In standard mode a read request returns the head word on the next clock, and the `empty` and `full` flags apply. In fall-through mode the head word is placed on `rd_data` without a request, and `out_rdy` and `in_rdy` act as the handshake. A rewind input moves the read position back to the first byte written since reset, so a stored burst can be replayed.

The controller has three states. In `ST_STD` (standard mode) it stays put. In fall-through mode it is in `ST_FWFT_DRY` while the output register is empty. It moves to `ST_FWFT_HOLD` once enough bytes are stored, or when a rewind succeeds. It goes from `ST_FWFT_HOLD` back to `ST_FWFT_DRY` when a read takes the last word, or when a rewind finds too few bytes. Reset selects `ST_STD` or `ST_FWFT_DRY` from `cfg_fwft`.

Top module: `bus_match_fifo`

## Requirements
- R1: While `mrst` is high the queue is emptied and `rd_data` is 0. With `cfg_fwft`=0 this gives `empty`=1, `full`=0, `out_rdy`=0, `in_rdy`=0. With `cfg_fwft`=1 it gives `empty`=0, `full`=0, `out_rdy`=0, `in_rdy`=1.
- R2: `cfg_in_wide`, `cfg_out_wide`, `cfg_big_end` and `cfg_fwft` are captured on each clock edge where `mrst` is high. They have no effect at any other time.
- R3: A narrow write (`cfg_in_wide`=0) stores `wr_data[8:0]`. A wide write stores two bytes: `wr_data[17:9]` first when `cfg_big_end`=1, and `wr_data[8:0]` first otherwise.
- R4: A narrow read gives `{9'b0, byte}`. A wide read puts the earlier byte in `rd_data[17:9]` when `cfg_big_end`=1, and in `rd_data[8:0]` otherwise.
- R5: In standard mode, when `rd_en` is high and `empty` is 0 at an edge, `rd_data` takes the head word after that edge. Otherwise `rd_data` holds, including when `rd_en` is high while `empty` is 1.
- R6: In standard mode, `empty` is 1 exactly when fewer bytes are stored than one read needs (1 for narrow, 2 for wide).
- R7: `full` (standard mode) is 1, and `in_rdy` (fall-through mode) is 0, when the free bytes are fewer than one write needs. A write at such an edge is dropped. The capacity is DEPTH bytes.
- R8: A write and a read at the same edge both take effect.
- R9: In fall-through mode, a write at edge k into an empty queue makes `out_rdy` 1 after edge k+1, with the head word on `rd_data`. A `rd_en` while `out_rdy`=1 moves to the next word. `out_rdy` falls after the edge where the last word is taken. Without `rd_en`, `out_rdy` and `rd_data` hold.
- R10: A `rewind` at an edge moves the read position to the first byte written since reset, and `rd_en` and `wr_en` at that edge are ignored. In standard mode the next read returns that first word. In fall-through mode `rd_data` shows it, with `out_rdy`=1, right after the rewind edge. This holds while no more than DEPTH bytes have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high; configuration is captured while high |
| cfg_in_wide | input | 1 | 1: 18-bit writes, 0: 9-bit writes |
| cfg_out_wide | input | 1 | 1: 18-bit reads, 0: 9-bit reads |
| cfg_big_end | input | 1 | 1: earlier byte in the upper half of an 18-bit word |
| cfg_fwft | input | 1 | 1: fall-through timing, 0: standard timing |
| wr_en | input | 1 | Write request |
| wr_data | input | 18 | Write word |
| rd_en | input | 1 | Read request (standard) or advance (fall-through) |
| rewind | input | 1 | Restart reading from the first byte written since reset |
| rd_data | output | 18 | Read word |
| empty | output | 1 | Standard mode: not enough bytes for a read |
| full | output | 1 | Standard mode: not enough space for a write |
| out_rdy | output | 1 | Fall-through mode: `rd_data` holds a valid word |
| in_rdy | output | 1 | Fall-through mode: a write would be accepted |

## Verification
Some properties are checked on every clock. Writes never push the stored byte count past capacity, and reads never take more bytes than are present. A write while `full` leaves the count unchanged. A standard read while `empty` leaves `rd_data` unchanged. A held fall-through word stays put until it is read. The captured configuration stays frozen outside reset. Other behaviour only the bench scenarios can show: the byte placement for each width and byte-order pairing, the exact edges at which `out_rdy` rises and falls, the word returned after a rewind, and the capacity limit at DEPTH−1 and DEPTH bytes.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
    typedef logic [8:0] byte9_t;

    typedef enum logic [1:0] {
        ST_STD,
        ST_FWFT_DRY,
        ST_FWFT_HOLD
    } bmf_state_t;
endpackage

// File: rtl/bmf_pack.sv
module bmf_pack
    import bmf_pkg::*;
(
    input  logic        wide,
    input  logic        big,
    input  logic [17:0] data,
    output byte9_t      first,
    output byte9_t      second
);
    // Order the two halves of an incoming word (R3)
    always_comb begin
        if (wide && big) begin
            first  = data[17:9];
            second = data[8:0];
        end else begin
            first  = data[8:0];
            second = data[17:9];
        end
    end
endmodule

// File: rtl/bmf_unpack.sv
module bmf_unpack
    import bmf_pkg::*;
(
    input  logic        wide,
    input  logic        big,
    input  byte9_t      early,
    input  byte9_t      late,
    output logic [17:0] word
);
    // Assemble an outgoing word from the two oldest bytes (R4)
    always_comb begin
        if (!wide)
            word = {9'b0, early};
        else if (big)
            word = {early, late};
        else
            word = {late, early};
    end
endmodule

// File: rtl/bmf_store.sv
module bmf_store
    import bmf_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic              clk,
    input  logic              mrst,
    input  logic              push,
    input  logic              push_two,
    input  byte9_t            in_b0,
    input  byte9_t            in_b1,
    input  logic              pop,
    input  logic              pop_two,
    input  logic              rewind,
    input  logic [1:0]        rewind_skip,
    output logic [$clog2(DEPTH):0] count,
    output logic [$clog2(DEPTH):0] written,
    output byte9_t            head0,
    output byte9_t            head1,
    output byte9_t            start0,
    output byte9_t            start1
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW:0] DEPTH_X = (CW+1)'(DEPTH);

    byte9_t          mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic [CW-1:0]   push_n;
    logic [CW-1:0]   pop_n;
    logic [CW:0]     wsum;

    assign push_n = push ? (push_two ? CW'(2) : CW'(1)) : '0;
    assign pop_n  = pop  ? (pop_two  ? CW'(2) : CW'(1)) : '0;
    assign wsum   = {1'b0, written} + {1'b0, push_n};

    assign head0  = mem[rd_ptr];
    assign head1  = mem[rd_ptr + AW'(1)];
    assign start0 = mem[0];
    assign start1 = mem[1];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= in_b0;
            if (push_two)
                mem[wr_ptr + AW'(1)] <= in_b1;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            written <= '0;
        end else begin
            wr_ptr  <= wr_ptr + push_n[AW-1:0];
            written <= (wsum > DEPTH_X) ? DEPTH_X[CW-1:0] : wsum[CW-1:0];
            if (rewind) begin
                rd_ptr <= AW'(rewind_skip);
                count  <= written - CW'(rewind_skip);
            end else begin
                rd_ptr <= rd_ptr + pop_n[AW-1:0];
                count  <= count + push_n - pop_n;
            end
        end
    end

    // R7: a granted write always fits in the free space
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (mrst)
        push |-> ({1'b0, count} + {1'b0, push_n}) <= DEPTH_X);

    // R6: a granted read never takes more bytes than are stored
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (mrst)
        pop |-> count >= pop_n);
endmodule

// File: rtl/bus_match_fifo.sv
module bus_match_fifo
    import bmf_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic        clk,
    input  logic        mrst,
    input  logic        cfg_in_wide,
    input  logic        cfg_out_wide,
    input  logic        cfg_big_end,
    input  logic        cfg_fwft,
    input  logic        wr_en,
    input  logic [17:0] wr_data,
    input  logic        rd_en,
    input  logic        rewind,
    output logic [17:0] rd_data,
    output logic        empty,
    output logic        full,
    output logic        out_rdy,
    output logic        in_rdy
);
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic in_wide_q, out_wide_q, big_q, fwft_q;
    bmf_state_t state, nxt;

    logic [CW-1:0] count, written, space, in_need, out_need;
    logic          no_room, have, rw_ok, rw_load;
    logic          push, pop;
    logic [1:0]    skip;
    byte9_t        in_b0, in_b1, head0, head1, start0, start1;
    logic [17:0]   head_word, start_word;

    // configuration capture, only while reset is held (R2)
    always_ff @(posedge clk) begin
        if (mrst) begin
            in_wide_q  <= cfg_in_wide;
            out_wide_q <= cfg_out_wide;
            big_q      <= cfg_big_end;
            fwft_q     <= cfg_fwft;
        end
    end

    assign in_need  = in_wide_q  ? CW'(2) : CW'(1);
    assign out_need = out_wide_q ? CW'(2) : CW'(1);
    assign space    = CAP - count;
    assign no_room  = space < in_need;
    assign have     = count >= out_need;
    assign rw_ok    = written >= out_need;
    assign rw_load  = rewind && (state != ST_STD) && rw_ok;
    assign skip     = rw_load ? (out_wide_q ? 2'd2 : 2'd1) : 2'd0;
    assign push     = wr_en && !no_room && !rewind;
    assign pop      = !rewind && have && (rd_en || state == ST_FWFT_DRY);

    bmf_pack u_pack (
        .wide(in_wide_q), .big(big_q), .data(wr_data),
        .first(in_b0), .second(in_b1)
    );

    bmf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .mrst(mrst),
        .push(push), .push_two(in_wide_q), .in_b0(in_b0), .in_b1(in_b1),
        .pop(pop), .pop_two(out_wide_q),
        .rewind(rewind), .rewind_skip(skip),
        .count(count), .written(written),
        .head0(head0), .head1(head1), .start0(start0), .start1(start1)
    );

    bmf_unpack u_unpack_head (
        .wide(out_wide_q), .big(big_q), .early(head0), .late(head1),
        .word(head_word)
    );

    bmf_unpack u_unpack_start (
        .wide(out_wide_q), .big(big_q), .early(start0), .late(start1),
        .word(start_word)
    );

    // state register
    always_ff @(posedge clk) begin
        if (mrst)
            state <= cfg_fwft ? ST_FWFT_DRY : ST_STD;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_STD:       nxt = ST_STD;
            ST_FWFT_DRY: begin
                if (rewind)
                    nxt = rw_ok ? ST_FWFT_HOLD : ST_FWFT_DRY;
                else if (have)
                    nxt = ST_FWFT_HOLD;
            end
            ST_FWFT_HOLD: begin
                if (rewind)
                    nxt = rw_ok ? ST_FWFT_HOLD : ST_FWFT_DRY;
                else if (rd_en && !have)
                    nxt = ST_FWFT_DRY;
            end
            default:      nxt = ST_STD;
        endcase
    end

    // output word register
    always_ff @(posedge clk) begin
        if (mrst)
            rd_data <= '0;
        else if (rw_load)
            rd_data <= start_word;
        else if (pop)
            rd_data <= head_word;
    end

    // flags
    always_comb begin
        empty   = 1'b0;
        full    = 1'b0;
        out_rdy = 1'b0;
        in_rdy  = 1'b0;
        unique case (state)
            ST_STD: begin
                empty = !have;
                full  = no_room;
            end
            ST_FWFT_DRY:  in_rdy = !no_room;
            ST_FWFT_HOLD: begin
                out_rdy = 1'b1;
                in_rdy  = !no_room;
            end
            default: ;
        endcase
    end

    // R2: captured configuration never moves outside reset
    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (mrst)
        1'b1 |=> $stable({in_wide_q, out_wide_q, big_q, fwft_q}));

    // R5: a read while empty leaves the output word alone
    a_r5_empty_read_holds: assert property (@(posedge clk) disable iff (mrst)
        (state == ST_STD && rd_en && empty) |=> $stable(rd_data));

    // R7: a write while full changes nothing in the store
    a_r7_full_write_dropped: assert property (@(posedge clk) disable iff (mrst)
        (full && wr_en && !rd_en && !rewind) |=> $stable(count));

    // R9: a presented word stays until it is taken
    a_r9_hold_until_read: assert property (@(posedge clk) disable iff (mrst)
        (out_rdy && !rd_en && !rewind) |=> (out_rdy && $stable(rd_data)));
endmodule

// File: tb/bus_match_fifo_tb.sv
module bus_match_fifo_tb_top;
    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        cfg_in_wide = 1'b0, cfg_out_wide = 1'b0, cfg_big_end = 1'b0, cfg_fwft = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rewind = 1'b0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        empty, full, out_rdy, in_rdy;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;

    bus_match_fifo #(.DEPTH(512)) dut_i (
        .clk(clk), .mrst(mrst),
        .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide),
        .cfg_big_end(cfg_big_end), .cfg_fwft(cfg_fwft),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rewind(rewind),
        .rd_data(rd_data), .empty(empty), .full(full),
        .out_rdy(out_rdy), .in_rdy(in_rdy)
    );

    // {in_wide, out_wide, big_end, expected first word, empty after one read}
    localparam logic [21:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 18'h0013C, 1'b0},
        {1'b0, 1'b0, 1'b0, 18'h0013C, 1'b0},
        {1'b0, 1'b1, 1'b1, 18'h27842, 1'b1},
        {1'b0, 1'b1, 1'b0, 18'h0853C, 1'b1},
        {1'b1, 1'b0, 1'b1, 18'h000A5, 1'b0},
        {1'b1, 1'b0, 1'b0, 18'h0013C, 1'b0},
        {1'b1, 1'b1, 1'b1, 18'h14B3C, 1'b0},
        {1'b1, 1'b1, 1'b0, 18'h14B3C, 1'b0}
    };
    localparam logic [17:0] W0 = 18'h14B3C;
    localparam logic [17:0] W1 = 18'h3E042;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic iw, input logic ow, input logic be, input logic ff);
        cfg_in_wide = iw; cfg_out_wide = ow; cfg_big_end = be; cfg_fwft = ff;
        wr_en = 0; rd_en = 0; rewind = 0; mrst = 1;
        tick();
        tick();
        mrst = 0;
    endtask

    task automatic put(input logic [17:0] d);
        wr_en = 1; wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state, standard mode
        do_reset(0, 0, 0, 0);
        check("R1 empty", 18'(empty), 18'd1);
        check("R1 full", 18'(full), 18'd0);
        check("R1 out_rdy", 18'(out_rdy), 18'd0);
        check("R1 in_rdy", 18'(in_rdy), 18'd0);
        check("R1 rd_data", rd_data, 18'd0);

        // R3 R4 R6 R2: width and byte-order table; config inputs flipped after reset
        for (int v = 0; v < 8; v++) begin
            do_reset(VEC[v][21], VEC[v][20], VEC[v][19], 1'b0);
            cfg_in_wide = ~VEC[v][21]; cfg_out_wide = ~VEC[v][20];
            cfg_big_end = ~VEC[v][19]; cfg_fwft = 1'b1;
            put(W0);
            put(W1);
            rd_en = 1;
            tick();
            rd_en = 0;
            check("R3/R4 first word", rd_data, VEC[v][18:1]);
            check("R6 empty after read", 18'(empty), 18'(VEC[v][0]));
            check("R2 mode stays standard", 18'(out_rdy), 18'd0);
        end

        // R6: wide read needs two bytes
        do_reset(0, 1, 1, 0);
        put(18'h00011);
        check("R6 one byte still empty", 18'(empty), 18'd1);
        rd_en = 1;
        tick();
        rd_en = 0;
        check("R5 read while empty ignored", rd_data, 18'd0);
        put(18'h00022);
        check("R6 two bytes not empty", 18'(empty), 18'd0);

        // R8: simultaneous write and read
        do_reset(0, 0, 0, 0);
        put(18'h000A1);
        wr_en = 1; wr_data = 18'h000B2; rd_en = 1;
        tick();
        wr_en = 0; rd_en = 0;
        check("R8 read returns old head", rd_data, 18'h000A1);
        check("R8 new byte present", 18'(empty), 18'd0);
        rd_en = 1;
        tick();
        rd_en = 0;
        check("R8 second byte", rd_data, 18'h000B2);
        check("R6 drained", 18'(empty), 18'd1);

        // R7: capacity with narrow writes
        do_reset(0, 0, 0, 0);
        for (int i = 0; i < 511; i++) put(18'(i));
        check("R7 not full at DEPTH-1", 18'(full), 18'd0);
        put(18'h001FF);
        check("R7 full at DEPTH", 18'(full), 18'd1);
        put(18'h000AB);
        for (int i = 0; i < 512; i++) begin
            rd_en = 1;
            tick();
        end
        rd_en = 0;
        check("R7 last byte is not dropped write", rd_data, 18'h001FF);
        check("R7 drained after DEPTH reads", 18'(empty), 18'd1);

        // R7: wide writes need two free bytes
        do_reset(1, 1, 1, 0);
        for (int i = 0; i < 255; i++) put(18'(i));
        check("R7 wide not full at 510 bytes", 18'(full), 18'd0);
        put(18'h00001);
        check("R7 wide full at 512 bytes", 18'(full), 18'd1);

        // R1 R9: fall-through timing
        do_reset(0, 0, 0, 1);
        check("R1 fwft out_rdy", 18'(out_rdy), 18'd0);
        check("R1 fwft in_rdy", 18'(in_rdy), 18'd1);
        check("R1 fwft empty", 18'(empty), 18'd0);
        put(18'h00055);
        check("R9 not ready one edge after write", 18'(out_rdy), 18'd0);
        tick();
        check("R9 ready two edges after write", 18'(out_rdy), 18'd1);
        check("R9 head word shown", rd_data, 18'h00055);
        put(18'h00066);
        put(18'h00077);
        check("R9 held without read", rd_data, 18'h00055);
        rd_en = 1;
        tick();
        check("R9 advance 1", rd_data, 18'h00066);
        tick();
        check("R9 advance 2", rd_data, 18'h00077);
        check("R9 still ready", 18'(out_rdy), 18'd1);
        tick();
        rd_en = 0;
        check("R9 ready falls after last", 18'(out_rdy), 18'd0);

        // R10: fall-through rewind
        rewind = 1;
        tick();
        rewind = 0;
        check("R10 fwft first word at once", rd_data, 18'h00055);
        check("R10 fwft ready", 18'(out_rdy), 18'd1);
        rd_en = 1;
        tick();
        check("R10 fwft replay 2", rd_data, 18'h00066);
        tick();
        check("R10 fwft replay 3", rd_data, 18'h00077);
        tick();
        rd_en = 0;
        check("R10 fwft replay end", 18'(out_rdy), 18'd0);

        // R10: standard rewind, read at rewind edge ignored
        do_reset(0, 0, 0, 0);
        put(18'h00011);
        put(18'h00022);
        put(18'h00033);
        rd_en = 1;
        tick();
        tick();
        check("R5 second read", rd_data, 18'h00022);
        rewind = 1;
        tick();
        rewind = 0;
        check("R10 read at rewind edge ignored", rd_data, 18'h00022);
        tick();
        rd_en = 0;
        check("R10 replay first byte", rd_data, 18'h00011);

        finish_run();
    end
endmodule